// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent virtual-page-to-physical-frame translations and answers a lookup in the same cycle. The requester presents a virtual address, the current privilege mode and the access type (read or write). Every stored entry compares its tag against the upper virtual address bits in parallel. The block returns a hit flag, a physical address made of the stored frame number joined to the untranslated page offset, and a fault flag. The fault flag is raised when the matching entry does not allow that access type in that mode.

Misses are resolved outside the block. The requester walks the page tables and then installs the translation through the fill port. A fill uses the lowest-numbered empty slot when one exists. Once every slot is occupied, the fill replaces a slot chosen by a rotating pointer. A single invalidate-all input empties the whole cache in one cycle, for example on an address-space switch.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no lookup hits, and the replacement pointer starts at entry 0.
- R2: A fill becomes visible to lookups in the cycle after the clock edge that samples it, not in the cycle it is presented. The hit then returns physAddr = {fillPfn, lookupVa[12:0]}.
- R3: The virtual address is 34 bits. Bits [12:0] are the page offset and pass unchanged into physAddr[12:0]. Bits [33:13] form the 21-bit tag. physAddr is 34 bits, and its bits [33:13] are the 21-bit frame number.
- R4: On a miss, hit, fault and physAddr are all 0.
- R5: For a read (lookupWrite = 0) that hits, fault = NOT readEnable[lookupMode]. Bit 0 of the enable field belongs to kernel mode (lookupMode = 0) and bit 1 to user mode (lookupMode = 1).
- R6: For a write (lookupWrite = 1) that hits, fault = NOT writeEnable[lookupMode], with the same bit assignment as R5.
- R7: A fill is written into the lowest-indexed invalid entry whenever one exists, and the replacement pointer does not move.
- R8: When all entries are valid, a fill overwrites the entry the replacement pointer names. The pointer then advances by one and wraps from the last entry to entry 0.
- R9: When several valid entries hold the lookup tag, the lowest-indexed one supplies the frame and the enable bits.
- R10: invalAll clears every valid bit and returns the replacement pointer to 0 on the next edge. A fill presented in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupVa | input | 34 | Virtual address being translated |
| lookupMode | input | 1 | 0 = kernel, 1 = user |
| lookupWrite | input | 1 | 0 = read access, 1 = write access |
| hit | output | 1 | A valid entry matches the tag |
| fault | output | 1 | Hit, but the access is not permitted |
| physAddr | output | 34 | {frame, offset} on a hit, 0 on a miss |
| fillEn | input | 1 | Install a translation |
| fillTag | input | 21 | Virtual page tag to install |
| fillPfn | input | 21 | Physical frame number to install |
| fillRdEn | input | 2 | Read enables {user, kernel} |
| fillWrEn | input | 2 | Write enables {user, kernel} |
| invalAll | input | 1 | Clear every entry |

## Verification
Slot placement and the replacement pointer are internal, so an error in either shows up only later. The wrong entry gets evicted, and a tag that should still hit misses, or an old tag survives, on the first lookup after the cache fills up. The bench therefore keeps its own shadow of the entries and compares every lookup. Tags are drawn from a small pool so that evictions and repeated tags happen often. A bad permission bit or frame mux shows up on the very next lookup of that tag.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int IDX_MAX_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 clrAll;
    logic [IDX_MAX_W-1:0] wrIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic               invalAll,
  input  logic [ENTRIES-1:0] validVec,
  output ctlStrobe_t         strobe
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             anyFree;

  // lowest-indexed invalid slot
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clrAll = invalAll;
    strobe.wrEn   = fillEn && !invalAll;
    strobe.wrIdx  = IDX_MAX_W'(anyFree ? freeIdx : rrPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN || invalAll) begin
      rrPtr <= '0;
    end else if (fillEn && !anyFree) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int TAG_W    = 21,
  parameter int PFN_W    = 21,
  parameter int OFFSET_W = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [TAG_W-1:0]          fillTag,
  input  logic [PFN_W-1:0]          fillPfn,
  input  logic [1:0]                fillRdEn,
  input  logic [1:0]                fillWrEn,
  input  logic [TAG_W+OFFSET_W-1:0] lookupVa,
  input  logic                      lookupMode,
  input  logic                      lookupWrite,
  output logic [ENTRIES-1:0]        validVec,
  output logic                      hit,
  output logic                      fault,
  output logic [PFN_W+OFFSET_W-1:0] physAddr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0] tagArr [ENTRIES];
  logic [PFN_W-1:0] pfnArr [ENTRIES];
  logic [1:0]       rdArr  [ENTRIES];
  logic [1:0]       wrArr  [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  logic [TAG_W-1:0]    lookTag;
  logic [OFFSET_W-1:0] lookOff;
  logic [IDX_W-1:0]    selIdx;
  logic [IDX_W-1:0]    wrIdx;
  logic                permBit;

  assign lookTag = lookupVa[TAG_W+OFFSET_W-1:OFFSET_W];
  assign lookOff = lookupVa[OFFSET_W-1:0];
  assign wrIdx   = strobe.wrIdx[IDX_W-1:0];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN || strobe.clrAll) begin
          validVec[g] <= 1'b0;
        end else if (strobe.wrEn && wrIdx == IDX_W'(g)) begin
          validVec[g] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (strobe.wrEn && !strobe.clrAll && wrIdx == IDX_W'(g)) begin
          tagArr[g] <= fillTag;
          pfnArr[g] <= fillPfn;
          rdArr[g]  <= fillRdEn;
          wrArr[g]  <= fillWrEn;
        end
      end

      assign matchVec[g] = validVec[g] && (tagArr[g] == lookTag);
    end
  endgenerate

  // lowest index wins when tags repeat
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  always_comb begin
    hit      = |matchVec;
    permBit  = lookupWrite ? wrArr[selIdx][lookupMode] : rdArr[selIdx][lookupMode];
    fault    = hit && !permBit;
    physAddr = hit ? {pfnArr[selIdx], lookOff} : '0;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int TAG_W    = 21,
  parameter int PFN_W    = 21,
  parameter int OFFSET_W = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TAG_W+OFFSET_W-1:0] lookupVa,
  input  logic                      lookupMode,
  input  logic                      lookupWrite,
  output logic                      hit,
  output logic                      fault,
  output logic [PFN_W+OFFSET_W-1:0] physAddr,
  input  logic                      fillEn,
  input  logic [TAG_W-1:0]          fillTag,
  input  logic [PFN_W-1:0]          fillPfn,
  input  logic [1:0]                fillRdEn,
  input  logic [1:0]                fillWrEn,
  input  logic                      invalAll
);
  ctlStrobe_t         strobe;
  logic [ENTRIES-1:0] validVec;

  xlat_control #(.ENTRIES(ENTRIES)) u_ctl (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .invalAll(invalAll),
    .validVec(validVec), .strobe(strobe)
  );

  xlat_datapath #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .PFN_W(PFN_W), .OFFSET_W(OFFSET_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fillTag(fillTag), .fillPfn(fillPfn), .fillRdEn(fillRdEn), .fillWrEn(fillWrEn),
    .lookupVa(lookupVa), .lookupMode(lookupMode), .lookupWrite(lookupWrite),
    .validVec(validVec), .hit(hit), .fault(fault), .physAddr(physAddr)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int TAG_W    = 21,
  parameter int PFN_W    = 21,
  parameter int OFFSET_W = 13
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [TAG_W+OFFSET_W-1:0] lookupVa,
  input logic                      hit,
  input logic                      fault,
  input logic [PFN_W+OFFSET_W-1:0] physAddr,
  input logic                      fillEn,
  input logic [TAG_W-1:0]          fillTag,
  input logic                      invalAll
);
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (physAddr == '0 && !fault)); // R4

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[OFFSET_W-1:0] == lookupVa[OFFSET_W-1:0]); // R3

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> hit); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    invalAll |=> !hit); // R10

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !invalAll) |=>
      (lookupVa[TAG_W+OFFSET_W-1:OFFSET_W] != $past(fillTag) || hit)); // R2
endmodule

bind xlat_cache xlat_cache_chk #(
  .TAG_W(TAG_W), .PFN_W(PFN_W), .OFFSET_W(OFFSET_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lookupVa(lookupVa), .hit(hit), .fault(fault),
  .physAddr(physAddr), .fillEn(fillEn), .fillTag(fillTag), .invalAll(invalAll)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rstN;
  logic [33:0] lookupVa;
  logic        lookupMode, lookupWrite;
  logic        hit, fault;
  logic [33:0] physAddr;
  logic        fillEn;
  logic [20:0] fillTag, fillPfn;
  logic [1:0]  fillRdEn, fillWrEn;
  logic        invalAll;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  logic [20:0] mTag [N];
  logic [20:0] mPfn [N];
  logic [1:0]  mRd  [N];
  logic [1:0]  mWr  [N];
  bit          mVal [N];
  int          mPtr;

  always #10 clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rstN(rstN), .lookupVa(lookupVa), .lookupMode(lookupMode),
    .lookupWrite(lookupWrite), .hit(hit), .fault(fault), .physAddr(physAddr),
    .fillEn(fillEn), .fillTag(fillTag), .fillPfn(fillPfn), .fillRdEn(fillRdEn),
    .fillWrEn(fillWrEn), .invalAll(invalAll)
  );

  function automatic int findMatch(input logic [20:0] t);
    for (int i = 0; i < N; i++) if (mVal[i] && mTag[i] == t) return i;
    return -1;
  endfunction

  function automatic logic [33:0] expPa(input logic [33:0] va);
    int k = findMatch(va[33:13]);
    return (k < 0) ? 34'h0 : {mPfn[k], va[12:0]};
  endfunction

  function automatic bit expFault(input logic [33:0] va, input bit md, input bit wr);
    int k = findMatch(va[33:13]);
    if (k < 0) return 1'b0;
    return wr ? !mWr[k][md] : !mRd[k][md];
  endfunction

  task automatic modelEdge();
    if (invalAll) begin
      for (int i = 0; i < N; i++) mVal[i] = 0;
      mPtr = 0;
    end else if (fillEn) begin
      int k = -1;
      for (int i = N - 1; i >= 0; i--) if (!mVal[i]) k = i;
      if (k < 0) begin
        k = mPtr;
        mPtr = (mPtr + 1) % N;
      end
      mVal[k] = 1; mTag[k] = fillTag; mPfn[k] = fillPfn;
      mRd[k] = fillRdEn; mWr[k] = fillWrEn;
    end
  endtask

  task automatic checkNow(input string req);
    bit eh = findMatch(lookupVa[33:13]) >= 0;
    logic [33:0] ep = expPa(lookupVa);
    bit ef = expFault(lookupVa, lookupMode, lookupWrite);
    nChk++;
    if (hit !== eh || fault !== ef || physAddr !== ep) begin
      nBad++;
      $display("FAIL %s va=%h md=%0b wr=%0b: hit=%0b fault=%0b pa=%h expected hit=%0b fault=%0b pa=%h",
               req, lookupVa, lookupMode, lookupWrite, hit, fault, physAddr, eh, ef, ep);
    end
  endtask

  // one cycle: drive at negedge, check lookup, then clock the model
  task automatic cyc(input string req, input bit fe, input logic [20:0] ft,
                     input logic [20:0] fp, input logic [1:0] fr, input logic [1:0] fw,
                     input bit inv, input logic [33:0] va, input bit md, input bit wr);
    @(negedge clk);
    fillEn = fe; fillTag = ft; fillPfn = fp; fillRdEn = fr; fillWrEn = fw;
    invalAll = inv; lookupVa = va; lookupMode = md; lookupWrite = wr;
    #1 checkNow(req);
    @(posedge clk);
    modelEdge();
  endtask

  task automatic look(input string req, input logic [20:0] t, input bit md, input bit wr);
    cyc(req, 0, 21'h0, 21'h0, 2'b00, 2'b00, 0, {t, 13'(($urandom) & 13'h1fff)}, md, wr);
  endtask

  task automatic fill(input string req, input logic [20:0] t, input logic [20:0] p,
                      input logic [1:0] r, input logic [1:0] w);
    cyc(req, 1, t, p, r, w, 0, {t, 13'h0abc}, 0, 0);
  endtask

  initial begin
    #3_000_000;
    nBad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      mVal[i] = 0; mTag[i] = '0; mPfn[i] = '0; mRd[i] = '0; mWr[i] = '0;
    end
    mPtr = 0;
    rstN = 0; fillEn = 0; invalAll = 0; fillTag = '0; fillPfn = '0;
    fillRdEn = '0; fillWrEn = '0; lookupVa = '0; lookupMode = 0; lookupWrite = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 / R4: empty after reset
    look("R1", 21'h000000, 0, 0);
    look("R4", 21'h1fffff, 1, 1);

    // R2: lookup in the fill cycle misses, next cycle hits
    cyc("R2", 1, 21'h012345, 21'h1abcde, 2'b11, 2'b11, 0, {21'h012345, 13'h1234}, 0, 0);
    look("R2", 21'h012345, 0, 0);
    look("R3", 21'h012345, 1, 1);

    // R5 / R6: every mode and access combination
    fill("R5", 21'h000100, 21'h000aaa, 2'b01, 2'b10);
    for (int m = 0; m < 2; m++) begin
      look("R5", 21'h000100, m[0], 0);
      look("R6", 21'h000100, m[0], 1);
    end
    fill("R6", 21'h000101, 21'h000bbb, 2'b10, 2'b01);
    for (int m = 0; m < 2; m++) begin
      look("R5", 21'h000101, m[0], 0);
      look("R6", 21'h000101, m[0], 1);
    end

    // R9: a duplicate tag in a higher slot is shadowed
    fill("R9", 21'h012345, 21'h077777, 2'b00, 2'b00);
    look("R9", 21'h012345, 0, 0);

    // R10: clear while filling drops the fill
    cyc("R10", 1, 21'h055555, 21'h1, 2'b11, 2'b11, 1, {21'h012345, 13'h0}, 0, 0);
    look("R10", 21'h012345, 0, 0);
    look("R10", 21'h055555, 0, 0);

    // R7 / R8: fill all slots, then replace in rotation
    for (int i = 0; i < N; i++) fill("R7", 21'(21'h100 + i), 21'(21'h5000 + i), 2'b11, 2'b11);
    for (int i = 0; i < N; i++) look("R7", 21'(21'h100 + i), 1, 0);
    for (int i = 0; i < 5; i++) fill("R8", 21'(21'h900 + i), 21'(21'h6000 + i), 2'b11, 2'b01);
    for (int i = 0; i < 8; i++) look("R8", 21'(21'h100 + i), 0, 1);
    for (int i = 0; i < 5; i++) look("R8", 21'(21'h900 + i), 1, 1);

    // R10 then R7: freed slots are refilled from index 0 again
    cyc("R10", 0, 21'h0, 21'h0, 2'b00, 2'b00, 1, {21'h000100, 13'h0}, 0, 0);
    fill("R7", 21'h000aaa, 21'h000123, 2'b11, 2'b11);
    look("R7", 21'h000aaa, 0, 0);

    // random traffic over a small tag pool
    for (int n = 0; n < 6000; n++) begin
      bit fe = ($urandom % 3) == 0;
      bit inv = ($urandom % 400) == 0;
      logic [20:0] ft = 21'h1a0000 | 21'($urandom % 48);
      logic [20:0] lt = 21'h1a0000 | 21'($urandom % 48);
      cyc("R8", fe, ft, 21'($urandom), 2'($urandom), 2'($urandom), inv,
          {lt, 13'($urandom)}, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule